// File: doc/BRIEF.md
# Debug Abstract Command Sequencer

This block sits in a processor debug module and turns a 32-bit abstract command into a short program for the halted hart. It does not move any data itself. It checks the command and then writes a sequence of RV64 instruction words into the abstract-instruction buffer, one word per clock. When the last word is written, it raises the GO flag of the selected hart. The hart runs the buffer and moves the data between the target register (or memory) and the debug data area. The hart then reports back on `cmd_done`.

The shape of the program depends on several things: the target class (CSR, integer register, floating-point register), the access width, the direction, the scratch save/restore the target needs, and whether the sequence chains into the program buffer. Memory-access commands get their own fixed-shape program. This program has an optional address post-increment. Commands that are malformed, unsupported or issued at the wrong time set a sticky 3-bit error code and launch nothing.

Top module: `abscmd_seq`

## Requirements
- R1: The command kind is in bits [31:24]. Kind 0 is a register access and kind 2 is a memory access. Any other kind sets `cmd_err` to 2 (not supported), writes no buffer slot and leaves `busy` low.
- R2: A command with a supported kind, issued while `hart_halted` is low, sets `cmd_err` to 4 and launches nothing.
- R3: A nonzero `cmd_err` holds until `err_clr` is pulsed, which zeroes it. While it is nonzero, commands are ignored. A command that arrives while `busy` is high sets `cmd_err` to 1.
- R4: This requirement covers a register access with the transfer bit (17) set to a CSR number below 0x1000, with `csr_access_en` high. The program first saves s0 to dscratch0 (0x7B2) and ends by restoring s0 from it. For a write (bit 16 set), s0 is loaded from the data area and then the CSR is written from s0. For a read, the CSR is read into s0 and then s0 is stored to the data area.
- R5: The size code is in bits [22:20]. Code 2 selects 32-bit load/store (funct3 2) and code 3 selects 64-bit (funct3 3). Any other code with transfer set gives `cmd_err` 2.
- R6: Register numbers 0x1000–0x101F select integer register (regno−0x1000), which is loaded or stored directly at the data area. A write to x8 (s0) appends a copy of s0 into dscratch0.
- R7: Register numbers 0x1020–0x103F select a floating-point register, using FP loads for writes and FP stores for reads. These are accepted only when `fpr_access_en` is high. The access is wrapped in a prologue and an epilogue. Prologue: save s0, copy mstatus (0x300) to dscratch1 (0x7B3), then `lui s0,6` and `csrrs x0,mstatus,s0`. Epilogue: restore mstatus from dscratch1, then restore s0.
- R8: The last slot of a register-access program depends on the postexec bit (18). With the bit set, it is `jal x0` with offset (program-buffer base − abstract base − 4×slot). With the bit clear, it is `ebreak` (0x00100073). With the transfer bit clear, the program is that last slot alone.
- R9: A launch writes slots 0..n−1 on consecutive cycles with `buf_we` high. `busy` rises on acceptance. The GO bit of the latched hart rises with the last write. The same event clears `cmd_complete` and loads `rti_left` with the configured countdown.
- R10: `rti_left` counts down once per cycle after GO. Completion happens one cycle after `cmd_done` has been seen with `rti_left` at zero. Completion clears GO and `busy` and sets `cmd_complete`. A `cmd_done` that comes earlier is remembered.
- R11: This requirement covers a memory access (kind 2). The virtual bit 23 must be clear and the size code must be at most 3, or else `cmd_err` is 2. The program saves s0/s1 to dscratch0/1. It then does one of two things. A read loads the address from data word 1, loads the sized value through it, and stores the value to data word 0. A write loads data word 0 and the address, then stores the sized value. When bit 19 is set, the address in data word 1 is increased by the access size. The program then restores s0/s1 and ends in `ebreak`.
- R12: Register numbers outside the enabled classes, with transfer set, give `cmd_err` 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a new command |
| cmd_word | input | 32 | Abstract command word |
| hart_sel | input | HSEL_W | Selected hart index |
| hart_halted | input | 1 | Selected hart is halted |
| csr_access_en | input | 1 | Enables CSR targets |
| fpr_access_en | input | 1 | Enables floating-point register targets |
| cmd_done | input | 1 | Hart has finished the buffer |
| err_clr | input | 1 | Clears the error code |
| buf_we | output | 1 | Buffer write enable |
| buf_idx | output | ABUF_AW | Buffer slot index |
| buf_wdata | output | 32 | Instruction word written |
| go_flags | output | HARTS | Per-hart GO flags |
| busy | output | 1 | Command in progress |
| cmd_err | output | 3 | Sticky error code |
| cmd_complete | output | 1 | Last command has completed |
| rti_left | output | RTI_W | Run-test-idle countdown |

## Verification
Some properties are checked by the assertions on every cycle. Buffer writes and GO occur only while busy. At most one GO bit is set. Slot indices step by one during a fill. A nonzero error holds until it is cleared. The countdown falls by one per cycle, and busy cannot drop while it is nonzero. The exact instruction words are checked only by the bench scenarios. So are the length of each program shape, the jal offset, and the error code chosen for each kind of rejected command. Each scenario compares every written slot against words the bench assembles from the field encodings.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

  localparam int MAXW   = 12;
  localparam int SLOT_W = $clog2(MAXW + 1);

  localparam logic [2:0] ERR_NONE   = 3'd0;
  localparam logic [2:0] ERR_BUSY   = 3'd1;
  localparam logic [2:0] ERR_NOTSUP = 3'd2;
  localparam logic [2:0] ERR_HALT   = 3'd4;

  localparam logic [7:0] KIND_REG = 8'd0;
  localparam logic [7:0] KIND_MEM = 8'd2;

  localparam logic [11:0] CSR_STATUS = 12'h300;
  localparam logic [11:0] CSR_SCR0   = 12'h7B2;
  localparam logic [11:0] CSR_SCR1   = 12'h7B3;

  localparam logic [4:0] XZ  = 5'd0;
  localparam logic [4:0] XS0 = 5'd8;
  localparam logic [4:0] XS1 = 5'd9;

  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_FLOAD  = 7'h07;
  localparam logic [6:0] OPC_IMM    = 7'h13;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_FSTORE = 7'h27;
  localparam logic [6:0] OPC_SYS    = 7'h73;
  localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RUN} seq_state_t;

  typedef struct packed {
    logic [7:0]  kind;
    logic        virt;
    logic [2:0]  size;
    logic        postinc;
    logic        postexec;
    logic        transfer;
    logic        write;
    logic [15:0] regno;
  } cmd_t;

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                        logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [6:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction

  function automatic logic [31:0] enc_csrw(logic [11:0] csr, logic [4:0] rs);
    return enc_i(csr, rs, 3'd1, XZ, OPC_SYS);
  endfunction

  function automatic logic [31:0] enc_csrr(logic [11:0] csr, logic [4:0] rd);
    return enc_i(csr, XZ, 3'd2, rd, OPC_SYS);
  endfunction

  function automatic logic [31:0] enc_csrs(logic [11:0] csr, logic [4:0] rs);
    return enc_i(csr, rs, 3'd2, XZ, OPC_SYS);
  endfunction

  function automatic logic [31:0] enc_lui(logic [4:0] rd, logic [19:0] imm);
    return {imm, rd, 7'h37};
  endfunction

  function automatic logic [31:0] enc_jal0(logic [20:0] off);
    return {off[20], off[10:1], off[11], off[19:12], XZ, 7'h6F};
  endfunction

  function automatic logic in_csr(logic [15:0] r);
    return r < 16'h1000;
  endfunction

  function automatic logic in_gpr(logic [15:0] r);
    return r[15:5] == 11'h080;
  endfunction

  function automatic logic in_fpr(logic [15:0] r);
    return r[15:5] == 11'h081;
  endfunction

endpackage

// File: rtl/abscmd_decode.sv
module abscmd_decode
  import abscmd_pkg::*;
(
  input  logic [7:0]  kind_i,
  input  logic        virt_i,
  input  logic [2:0]  size_i,
  input  logic        transfer_i,
  input  logic [15:0] regno_i,
  input  logic        halted_i,
  input  logic        csr_en_i,
  input  logic        fpr_en_i,
  output logic [2:0]  err_o
);

  logic size_ok;
  logic target_ok;

  assign size_ok   = (size_i == 3'd2) || (size_i == 3'd3);
  assign target_ok = (in_csr(regno_i) && csr_en_i) || in_gpr(regno_i) ||
                     (in_fpr(regno_i) && fpr_en_i);

  always_comb begin
    err_o = ERR_NONE;
    if (kind_i != KIND_REG && kind_i != KIND_MEM) begin
      err_o = ERR_NOTSUP;
    end else if (!halted_i) begin
      err_o = ERR_HALT;
    end else if (kind_i == KIND_MEM) begin
      if (virt_i || size_i > 3'd3) err_o = ERR_NOTSUP;
    end else if (transfer_i) begin
      if (!size_ok || !target_ok) err_o = ERR_NOTSUP;
    end
  end

endmodule

// File: rtl/abscmd_progen.sv
module abscmd_progen
  import abscmd_pkg::*;
#(
  parameter logic [11:0] DATA_ADDR = 12'h380,
  parameter int          JAL_SPAN  = 64
) (
  input  logic                       is_mem_i,
  input  logic [2:0]                 size_i,
  input  logic                       postinc_i,
  input  logic                       postexec_i,
  input  logic                       transfer_i,
  input  logic                       write_i,
  input  logic [15:0]                regno_i,
  output logic [MAXW-1:0][31:0]      words_o,
  output logic [SLOT_W-1:0]          len_o
);

  localparam logic [11:0] ARG0 = DATA_ADDR;
  localparam logic [11:0] ARG1 = DATA_ADDR + 12'd8;

  logic [2:0]  f3;
  logic [4:0]  rn;
  logic        fp;
  logic [11:0] step;

  assign f3   = {1'b0, size_i[1:0]};
  assign rn   = regno_i[4:0];
  assign fp   = in_fpr(regno_i);
  assign step = 12'd1 << size_i[1:0];

  always_comb begin
    logic [SLOT_W-1:0] n;
    logic [20:0]       off;
    words_o = '0;
    n       = '0;
    off     = '0;
    if (is_mem_i) begin
      words_o[n] = enc_csrw(CSR_SCR0, XS0); n = n + 1'b1;
      words_o[n] = enc_csrw(CSR_SCR1, XS1); n = n + 1'b1;
      if (write_i) begin
        words_o[n] = enc_i(ARG0, XZ, 3'd3, XS0, OPC_LOAD);  n = n + 1'b1;
        words_o[n] = enc_i(ARG1, XZ, 3'd3, XS1, OPC_LOAD);  n = n + 1'b1;
        words_o[n] = enc_s(12'd0, XS0, XS1, f3, OPC_STORE); n = n + 1'b1;
      end else begin
        words_o[n] = enc_i(ARG1, XZ, 3'd3, XS0, OPC_LOAD);  n = n + 1'b1;
        words_o[n] = enc_i(12'd0, XS0, f3, XS0, OPC_LOAD);  n = n + 1'b1;
        words_o[n] = enc_s(ARG0, XS0, XZ, 3'd3, OPC_STORE); n = n + 1'b1;
      end
      if (postinc_i) begin
        words_o[n] = enc_i(ARG1, XZ, 3'd3, XS1, OPC_LOAD);  n = n + 1'b1;
        words_o[n] = enc_i(step, XS1, 3'd0, XS1, OPC_IMM);  n = n + 1'b1;
        words_o[n] = enc_s(ARG1, XS1, XZ, 3'd3, OPC_STORE); n = n + 1'b1;
      end
      words_o[n] = enc_csrr(CSR_SCR0, XS0); n = n + 1'b1;
      words_o[n] = enc_csrr(CSR_SCR1, XS1); n = n + 1'b1;
      words_o[n] = WORD_EBREAK;             n = n + 1'b1;
    end else begin
      if (transfer_i) begin
        if (fp) begin
          words_o[n] = enc_csrw(CSR_SCR0, XS0);   n = n + 1'b1;
          words_o[n] = enc_csrr(CSR_STATUS, XS0); n = n + 1'b1;
          words_o[n] = enc_csrw(CSR_SCR1, XS0);   n = n + 1'b1;
          words_o[n] = enc_lui(XS0, 20'd6);       n = n + 1'b1;
          words_o[n] = enc_csrs(CSR_STATUS, XS0); n = n + 1'b1;
        end
        if (in_csr(regno_i)) begin
          words_o[n] = enc_csrw(CSR_SCR0, XS0); n = n + 1'b1;
          if (write_i) begin
            words_o[n] = enc_i(DATA_ADDR, XZ, f3, XS0, OPC_LOAD); n = n + 1'b1;
            words_o[n] = enc_csrw(regno_i[11:0], XS0);            n = n + 1'b1;
          end else begin
            words_o[n] = enc_csrr(regno_i[11:0], XS0);             n = n + 1'b1;
            words_o[n] = enc_s(DATA_ADDR, XS0, XZ, f3, OPC_STORE); n = n + 1'b1;
          end
          words_o[n] = enc_csrr(CSR_SCR0, XS0); n = n + 1'b1;
        end else if (in_gpr(regno_i)) begin
          if (write_i) words_o[n] = enc_i(DATA_ADDR, XZ, f3, rn, OPC_LOAD);
          else         words_o[n] = enc_s(DATA_ADDR, rn, XZ, f3, OPC_STORE);
          n = n + 1'b1;
          if (write_i && rn == XS0) begin
            words_o[n] = enc_csrw(CSR_SCR0, XS0); n = n + 1'b1;
          end
        end else if (fp) begin
          if (write_i) words_o[n] = enc_i(DATA_ADDR, XZ, f3, rn, OPC_FLOAD);
          else         words_o[n] = enc_s(DATA_ADDR, rn, XZ, f3, OPC_FSTORE);
          n = n + 1'b1;
        end
        if (fp) begin
          words_o[n] = enc_csrr(CSR_SCR1, XS0);   n = n + 1'b1;
          words_o[n] = enc_csrw(CSR_STATUS, XS0); n = n + 1'b1;
          words_o[n] = enc_csrr(CSR_SCR0, XS0);   n = n + 1'b1;
        end
      end
      off = 21'(JAL_SPAN) - 21'({n, 2'b00});
      words_o[n] = postexec_i ? enc_jal0(off) : WORD_EBREAK;
      n = n + 1'b1;
    end
    len_o = n;
  end

endmodule

// File: rtl/abscmd_seq.sv
module abscmd_seq
  import abscmd_pkg::*;
#(
  parameter int          HARTS      = 4,
  parameter int          HSEL_W     = (HARTS > 1) ? $clog2(HARTS) : 1,
  parameter int          ABUF_AW    = 4,
  parameter logic [11:0] DATA_ADDR  = 12'h380,
  parameter int          ABS_BASE   = 32'h300,
  parameter int          PBUF_BASE  = 32'h340,
  parameter int          RTI_W      = 8,
  parameter int          RTI_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [31:0]        cmd_word,
  input  logic [HSEL_W-1:0]  hart_sel,
  input  logic               hart_halted,
  input  logic               csr_access_en,
  input  logic               fpr_access_en,
  input  logic               cmd_done,
  input  logic               err_clr,
  output logic               buf_we,
  output logic [ABUF_AW-1:0] buf_idx,
  output logic [31:0]        buf_wdata,
  output logic [HARTS-1:0]   go_flags,
  output logic               busy,
  output logic [2:0]         cmd_err,
  output logic               cmd_complete,
  output logic [RTI_W-1:0]   rti_left
);

  localparam int JAL_SPAN = PBUF_BASE - ABS_BASE;

  cmd_t                  cmd_in;
  cmd_t                  cmd_q;
  seq_state_t            state_q;
  logic [HSEL_W-1:0]     hart_q;
  logic [SLOT_W-1:0]     slot_q;
  logic                  done_seen_q;
  logic [2:0]            dec_err;
  logic [MAXW-1:0][31:0] prog_words;
  logic [SLOT_W-1:0]     prog_len;
  logic                  accept;
  logic                  finish;

  assign cmd_in = cmd_t'(cmd_word);
  assign accept = cmd_valid && (cmd_err == ERR_NONE);
  assign finish = (state_q == ST_RUN) && (cmd_done || done_seen_q) && (rti_left == '0);

  abscmd_decode decode_i (
    .kind_i     (cmd_in.kind),
    .virt_i     (cmd_in.virt),
    .size_i     (cmd_in.size),
    .transfer_i (cmd_in.transfer),
    .regno_i    (cmd_in.regno),
    .halted_i   (hart_halted),
    .csr_en_i   (csr_access_en),
    .fpr_en_i   (fpr_access_en),
    .err_o      (dec_err)
  );

  abscmd_progen #(
    .DATA_ADDR (DATA_ADDR),
    .JAL_SPAN  (JAL_SPAN)
  ) progen_i (
    .is_mem_i   (cmd_q.kind == KIND_MEM),
    .size_i     (cmd_q.size),
    .postinc_i  (cmd_q.postinc),
    .postexec_i (cmd_q.postexec),
    .transfer_i (cmd_q.transfer),
    .write_i    (cmd_q.write),
    .regno_i    (cmd_q.regno),
    .words_o    (prog_words),
    .len_o      (prog_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cmd_q        <= '0;
      hart_q       <= '0;
      slot_q       <= '0;
      done_seen_q  <= 1'b0;
      buf_we       <= 1'b0;
      buf_idx      <= '0;
      buf_wdata    <= '0;
      go_flags     <= '0;
      busy         <= 1'b0;
      cmd_err      <= ERR_NONE;
      cmd_complete <= 1'b0;
      rti_left     <= '0;
    end else begin
      buf_we <= 1'b0;
      if (err_clr) cmd_err <= ERR_NONE;

      if (accept) begin
        if (busy) begin
          cmd_err <= ERR_BUSY;
        end else if (dec_err != ERR_NONE) begin
          cmd_err <= dec_err;
        end else begin
          cmd_q        <= cmd_in;
          hart_q       <= hart_sel;
          slot_q       <= '0;
          busy         <= 1'b1;
          cmd_complete <= 1'b0;
          state_q      <= ST_FILL;
        end
      end

      case (state_q)
        ST_FILL: begin
          buf_we    <= 1'b1;
          buf_idx   <= ABUF_AW'(slot_q);
          buf_wdata <= prog_words[slot_q];
          slot_q    <= slot_q + 1'b1;
          if (slot_q == prog_len - 1'b1) begin
            go_flags[hart_q] <= 1'b1;
            rti_left         <= RTI_W'(RTI_CYCLES);
            done_seen_q      <= 1'b0;
            state_q          <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (rti_left != '0) rti_left <= rti_left - 1'b1;
          if (cmd_done) done_seen_q <= 1'b1;
          if (finish) begin
            go_flags     <= '0;
            busy         <= 1'b0;
            cmd_complete <= 1'b1;
            done_seen_q  <= 1'b0;
            state_q      <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/abscmd_seq_chk.sv
module abscmd_seq_chk #(
  parameter int HARTS   = 4,
  parameter int HSEL_W  = 2,
  parameter int ABUF_AW = 4,
  parameter int RTI_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               err_clr,
  input logic               buf_we,
  input logic [ABUF_AW-1:0] buf_idx,
  input logic [HARTS-1:0]   go_flags,
  input logic               busy,
  input logic [2:0]         cmd_err,
  input logic               cmd_complete,
  input logic [RTI_W-1:0]   rti_left
);

  a_r9_write_while_busy: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> busy);

  a_r9_go_single_hart: assert property (@(posedge clk) disable iff (rst)
    $onehot0(go_flags));

  a_r9_slot_steps: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we)) |-> (buf_idx == $past(buf_idx) + 1'b1));

  a_r10_go_while_busy: assert property (@(posedge clk) disable iff (rst)
    (|go_flags) |-> busy);

  a_r10_countdown: assert property (@(posedge clk) disable iff (rst)
    ((rti_left != '0) && (|go_flags)) |=> (rti_left == $past(rti_left) - 1'b1));

  a_r10_hold_busy: assert property (@(posedge clk) disable iff (rst)
    ((rti_left != '0) && busy && (|go_flags)) |=> busy);

  a_r10_complete_idle: assert property (@(posedge clk) disable iff (rst)
    cmd_complete |-> !busy);

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
    ((cmd_err != 3'd0) && !err_clr) |=> $stable(cmd_err));

endmodule

bind abscmd_seq abscmd_seq_chk #(
  .HARTS   (HARTS),
  .HSEL_W  (HSEL_W),
  .ABUF_AW (ABUF_AW),
  .RTI_W   (RTI_W)
) chk_i (.*);

// File: tb/abscmd_seq_tb_top.sv
module abscmd_seq_tb_top;

  localparam int CLK_P = 10;
  localparam logic [11:0] DA = 12'h380;
  localparam int SPAN = 32'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [1:0]  hart_sel = '0;
  logic        hart_halted = 1'b1;
  logic        csr_access_en = 1'b1;
  logic        fpr_access_en = 1'b1;
  logic        cmd_done = 1'b0;
  logic        err_clr = 1'b0;
  logic        buf_we;
  logic [3:0]  buf_idx;
  logic [31:0] buf_wdata;
  logic [3:0]  go_flags;
  logic        busy;
  logic [2:0]  cmd_err;
  logic        cmd_complete;
  logic [7:0]  rti_left;

  int checks = 0;
  int errors = 0;
  logic [31:0] cap [16];
  int cap_cnt = 0;
  logic [31:0] exp_w [16];
  int exp_n = 0;

  always #(CLK_P/2) clk = ~clk;

  abscmd_seq dut_i (.*);

  always @(negedge clk) if (buf_we) begin
    cap[buf_idx] = buf_wdata;
    cap_cnt = cap_cnt + 1;
  end

  function automatic logic [31:0] w_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] w_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3, logic [6:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction
  function automatic logic [31:0] w_csr(logic [11:0] c, logic [4:0] rs1, logic [2:0] f3,
                                        logic [4:0] rd);
    return {c, rs1, f3, rd, 7'h73};
  endfunction
  function automatic logic [31:0] w_jal(int off);
    logic [20:0] o;
    o = 21'(off);
    return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6F};
  endfunction
  function automatic logic [31:0] mk_reg(logic [2:0] sz, logic pe, logic tr, logic wr,
                                         logic [15:0] rg);
    return {8'd0, 1'b0, sz, 1'b0, pe, tr, wr, rg};
  endfunction
  function automatic logic [31:0] mk_mem(logic vt, logic [2:0] sz, logic pi, logic wr);
    return {8'd2, vt, sz, pi, 1'b0, 1'b0, wr, 16'd0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push(input logic [31:0] w);
    exp_w[exp_n] = w;
    exp_n++;
  endtask

  task automatic pulse_cmd(input logic [31:0] w, input logic [1:0] h);
    @(negedge clk);
    cmd_word = w; hart_sel = h; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic start_cmd(input logic [31:0] w, input logic [1:0] h, input string req);
    int t;
    cap_cnt = 0;
    pulse_cmd(w, h);
    t = 0;
    while (go_flags == '0 && t < 40) begin @(negedge clk); t++; end
    @(negedge clk);
    check(cap_cnt == exp_n, {req, " slot count"}, 32'(cap_cnt), 32'(exp_n));
    for (int i = 0; i < exp_n; i++)
      check(cap[i] === exp_w[i], {req, " word"}, cap[i], exp_w[i]);
    check(go_flags == (4'd1 << h), "R9 go of selected hart", 32'(go_flags), 32'(4'd1 << h));
    check(busy && !cmd_complete, "R9 busy set, complete cleared", {busy, cmd_complete}, 2'b10);
    exp_n = 0;
  endtask

  task automatic end_cmd(input bit chk_hold);
    int t;
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
    if (chk_hold) check(busy == 1'b1, "R10 busy held during countdown", 32'(busy), 1);
    t = 0;
    while (busy && t < 40) begin @(negedge clk); t++; end
    check(!busy && cmd_complete && go_flags == '0, "R10 completion",
          {busy, cmd_complete, go_flags}, 6'b010000);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check(cmd_err == 3'd0, "R3 clear", 32'(cmd_err), 0);
  endtask

  task automatic err_case(input logic [31:0] w, input logic [2:0] e, input string req);
    cap_cnt = 0;
    pulse_cmd(w, 2'd0);
    @(negedge clk);
    check(cmd_err == e, req, 32'(cmd_err), 32'(e));
    check(!busy && cap_cnt == 0 && go_flags == '0, {req, " no launch"},
          {busy, 4'(cap_cnt), go_flags}, 0);
    clear_err();
  endtask

  task automatic t_reset();
    check(!busy && cmd_err == 0 && go_flags == 0 && !buf_we && !cmd_complete,
          "R9 reset state", {busy, cmd_err, go_flags, buf_we}, 0);
  endtask

  task automatic t_csr_read();
    push(w_csr(12'h7B2, 8, 1, 0)); push(w_csr(12'h300, 0, 2, 8));
    push(w_s(DA, 8, 0, 2, 7'h23)); push(w_csr(12'h7B2, 0, 2, 8)); push(32'h0010_0073);
    start_cmd(mk_reg(3'd2, 1'b0, 1'b1, 1'b0, 16'h0300), 2'd1, "R4 R5 CSR read 32");
    end_cmd(1'b0);
  endtask

  task automatic t_csr_write_postexec();
    push(w_csr(12'h7B2, 8, 1, 0)); push(w_i(DA, 0, 3, 8, 7'h03));
    push(w_csr(12'h341, 8, 1, 0)); push(w_csr(12'h7B2, 0, 2, 8)); push(w_jal(SPAN - 16));
    start_cmd(mk_reg(3'd3, 1'b1, 1'b1, 1'b1, 16'h0341), 2'd3, "R4 R8 CSR write 64 postexec");
    end_cmd(1'b0);
  endtask

  task automatic t_gpr();
    push(w_i(DA, 0, 3, 8, 7'h03)); push(w_csr(12'h7B2, 8, 1, 0)); push(32'h0010_0073);
    start_cmd(mk_reg(3'd3, 1'b0, 1'b1, 1'b1, 16'h1008), 2'd0, "R6 s0 write copies scratch");
    end_cmd(1'b0);
    push(w_s(DA, 5, 0, 2, 7'h23)); push(32'h0010_0073);
    start_cmd(mk_reg(3'd2, 1'b0, 1'b1, 1'b0, 16'h1005), 2'd2, "R6 x5 read");
    end_cmd(1'b0);
  endtask

  task automatic t_fpr();
    push(w_csr(12'h7B2, 8, 1, 0)); push(w_csr(12'h300, 0, 2, 8));
    push(w_csr(12'h7B3, 8, 1, 0)); push({20'd6, 5'd8, 7'h37});
    push(w_csr(12'h300, 8, 2, 0)); push(w_i(DA, 0, 3, 3, 7'h07));
    push(w_csr(12'h7B3, 0, 2, 8)); push(w_csr(12'h300, 8, 1, 0));
    push(w_csr(12'h7B2, 0, 2, 8)); push(32'h0010_0073);
    start_cmd(mk_reg(3'd3, 1'b0, 1'b1, 1'b1, 16'h1023), 2'd0, "R7 FPR write wrapped");
    end_cmd(1'b1);
    fpr_access_en = 1'b0;
    err_case(mk_reg(3'd3, 1'b0, 1'b1, 1'b1, 16'h1023), 3'd2, "R7 FPR disabled");
    fpr_access_en = 1'b1;
  endtask

  task automatic t_no_transfer();
    push(w_jal(SPAN));
    start_cmd(mk_reg(3'd0, 1'b1, 1'b0, 1'b0, 16'hFFFF), 2'd1, "R8 transfer clear postexec");
    end_cmd(1'b0);
  endtask

  task automatic t_mem_read_inc();
    push(w_csr(12'h7B2, 8, 1, 0)); push(w_csr(12'h7B3, 9, 1, 0));
    push(w_i(DA + 12'd8, 0, 3, 8, 7'h03)); push(w_i(12'd0, 8, 2, 8, 7'h03));
    push(w_s(DA, 8, 0, 3, 7'h23));
    push(w_i(DA + 12'd8, 0, 3, 9, 7'h03)); push(w_i(12'd4, 9, 0, 9, 7'h13));
    push(w_s(DA + 12'd8, 9, 0, 3, 7'h23));
    push(w_csr(12'h7B2, 0, 2, 8)); push(w_csr(12'h7B3, 0, 2, 9)); push(32'h0010_0073);
    start_cmd(mk_mem(1'b0, 3'd2, 1'b1, 1'b0), 2'd2, "R11 memory read postinc");
    end_cmd(1'b0);
    push(w_csr(12'h7B2, 8, 1, 0)); push(w_csr(12'h7B3, 9, 1, 0));
    push(w_i(DA, 0, 3, 8, 7'h03)); push(w_i(DA + 12'd8, 0, 3, 9, 7'h03));
    push(w_s(12'd0, 8, 9, 0, 7'h23));
    push(w_csr(12'h7B2, 0, 2, 8)); push(w_csr(12'h7B3, 0, 2, 9)); push(32'h0010_0073);
    start_cmd(mk_mem(1'b0, 3'd0, 1'b0, 1'b1), 2'd0, "R11 memory write byte");
    end_cmd(1'b0);
    err_case(mk_mem(1'b1, 3'd2, 1'b0, 1'b0), 3'd2, "R11 virtual rejected");
  endtask

  task automatic t_errors();
    err_case({8'd1, 24'd0}, 3'd2, "R1 unknown kind");
    hart_halted = 1'b0;
    err_case(mk_reg(3'd2, 1'b0, 1'b1, 1'b0, 16'h0300), 3'd4, "R2 hart running");
    hart_halted = 1'b1;
    err_case(mk_reg(3'd1, 1'b0, 1'b1, 1'b0, 16'h1001), 3'd2, "R5 bad size");
    err_case(mk_reg(3'd2, 1'b0, 1'b1, 1'b0, 16'h2000), 3'd2, "R12 regno out of range");
    csr_access_en = 1'b0;
    err_case(mk_reg(3'd2, 1'b0, 1'b1, 1'b0, 16'h0300), 3'd2, "R12 CSR disabled");
    csr_access_en = 1'b1;
  endtask

  task automatic t_sticky_and_busy();
    cap_cnt = 0;
    pulse_cmd({8'd7, 24'd0}, 2'd0);
    pulse_cmd(mk_reg(3'd2, 1'b0, 1'b1, 1'b0, 16'h1001), 2'd0);
    @(negedge clk);
    check(cmd_err == 3'd2 && !busy && cap_cnt == 0, "R3 sticky, command ignored",
          {cmd_err, busy}, 6'b0100);
    clear_err();
    push(w_s(DA, 1, 0, 2, 7'h23)); push(32'h0010_0073);
    start_cmd(mk_reg(3'd2, 1'b0, 1'b1, 1'b0, 16'h1001), 2'd0, "R3 launch before busy test");
    pulse_cmd(mk_reg(3'd2, 1'b0, 1'b1, 1'b0, 16'h1002), 2'd0);
    check(cmd_err == 3'd1 && busy, "R3 busy error", {cmd_err, busy}, 4'b0011);
    end_cmd(1'b0);
    clear_err();
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_csr_read();
    t_csr_write_postexec();
    t_gpr();
    t_fpr();
    t_no_transfer();
    t_mem_read_inc();
    t_errors();
    t_sticky_and_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule